// File: doc/BRIEF.md
# DMA Channel Transfer Length Counter

This block keeps the transfer length for one channel of a DMA controller. A host writes a 16-bit byte count as two 8-bit halves, then issues a start. While the channel is active, the bus side reports each completed transfer with a byte strobe or a word strobe. The counter subtracts one or two for each strobe. When the count runs out, the block raises a one-cycle terminal-count pulse and returns to idle.

For chained receive transfers, where data moves from the serial side into memory, a second 16-bit register sets the size of each memory buffer in bytes. A per-buffer counter reloads from it at start and on every buffer-start strobe, counts the same strobes, and pulses buffer-full when the buffer is used up. The block checks the chained receive setup at start. It refuses to start, and flags a configuration error, if the buffer length has not been written or if the length is one on a bus that can move words.

All pins are plain control and status signals. No data passes through the block, so it has no valid/ready stream interface and no back-pressure.

Top module: `dma_xfer_counter`

## Requirements
- R1: The byte count is written with `wr_sel`=0 for bits 7:0 and `wr_sel`=1 for bits 15:8. An accepted start copies it into `remaining`, and `active` goes high one cycle after the start.
- R2: While active, each `byte_done` lowers `remaining` by 1 at the next clock edge.
- R3: While active, each `word_done` lowers `remaining` by 2. If both strobes arrive in the same cycle, only the word counts. `remaining` never exceeds 65536.
- R4: A loaded count of zero starts the transfer at 65536 bytes. The transfer then ends after 65536 bytes.
- R5: The strobe that takes `remaining` to zero causes `term_cnt` to be high for exactly the next cycle, and `active` drops in that same cycle.
- R6: While idle, transfer strobes have no effect: `remaining` is unchanged and `term_cnt` stays low.
- R7: A `word_done` with one byte left sets `remaining` to 0, sets `odd_resid`, and pulses `term_cnt`. The next accepted start clears `odd_resid`.
- R8: In single-block mode (`chain_mode`=0), and in chained transmit (`chain_mode`=1, `rx_dir`=0), the buffer length is ignored. Start is accepted without it, `buf_left` stays 0, and `buf_full` never pulses.
- R9: In chained receive (`chain_mode`=1, `rx_dir`=1), a start is refused unless both length halves (`wr_sel`=2 for the low half, `wr_sel`=3 for the high half) have been written since reset. A refused start sets `cfg_err` and leaves `active` low. Each start attempt while idle updates `cfg_err`.
- R10: In chained receive with `word_bus`=1, a buffer length of 1 is refused with `cfg_err`. With `word_bus`=0, the same length is accepted.
- R11: In chained receive, `buf_left` loads the buffer length at start and on `buf_start`, with zero meaning 65536. Strobes lower it by 1 or 2, saturating at zero. Reaching zero pulses `buf_full` for one cycle. At zero it holds until reloaded.
- R12: Register writes are ignored while `active` is high. The next start after the transfer loads the value held before the blocked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count low, 1 count high, 2 length low, 3 length high |
| wr_data | input | 8 | Write data for one half |
| chain_mode | input | 1 | 1 selects chained-block mode, sampled at start |
| rx_dir | input | 1 | 1 selects serial-to-memory direction, sampled at start |
| word_bus | input | 1 | 1 when the bus may move words |
| start | input | 1 | Start request, honoured only while idle |
| buf_start | input | 1 | New receive buffer begins; reloads the buffer counter |
| byte_done | input | 1 | One byte transferred |
| word_done | input | 1 | One word transferred |
| active | output | 1 | Channel is transferring |
| remaining | output | 17 | Bytes still to transfer |
| buf_left | output | 17 | Bytes left in the current receive buffer |
| term_cnt | output | 1 | One-cycle pulse when the count is exhausted |
| buf_full | output | 1 | One-cycle pulse when the current buffer is filled |
| cfg_err | output | 1 | Last start attempt was refused |
| odd_resid | output | 1 | Last transfer ended with a word strobe on a single byte |

## Verification
The bench uses the default 8-bit half width, so the counters are 16 bits wide plus one bit for the 65536 case. At this width, holding the word strobe high for 32767 cycles brings a zero-loaded count down to its final bytes within the run, so the full-length end case is exercised to completion. Small loaded values bring the odd-byte saturation, the same-cycle strobe priority and the buffer reload corners within a few cycles.

// File: rtl/dxc_pkg.sv
`timescale 1ns/1ps
package dxc_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_LEN_LO = 2'd2,
    SEL_LEN_HI = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dxc_cfg_regs.sv
`timescale 1ns/1ps
module dxc_cfg_regs
  import dxc_pkg::*;
#(
  parameter int HALF_W = 8,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              busy,
  output logic [FULL_W-1:0] count_val,
  output logic [FULL_W-1:0] len_val,
  output logic              len_ok
);
  logic [1:0] seen;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [1:0] CSEL = (h == 0) ? 2'(SEL_CNT_LO) : 2'(SEL_CNT_HI);
    localparam logic [1:0] LSEL = (h == 0) ? 2'(SEL_LEN_LO) : 2'(SEL_LEN_HI);
    logic [HALF_W-1:0] cnt_h;
    logic [HALF_W-1:0] len_h;
    logic              len_seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_h    <= '0;
        len_h    <= '0;
        len_seen <= 1'b0;
      end else if (wr_en && !busy) begin
        if (wr_sel == CSEL) cnt_h <= wr_data;
        if (wr_sel == LSEL) begin
          len_h    <= wr_data;
          len_seen <= 1'b1;
        end
      end
    end

    assign count_val[h*HALF_W +: HALF_W] = cnt_h;
    assign len_val[h*HALF_W +: HALF_W]   = len_h;
    assign seen[h]                       = len_seen;
  end

  assign len_ok = &seen;

  // R12: nothing changes while the channel runs
  a_r12_write_block: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(count_val) && $stable(len_val)));
endmodule

// File: rtl/dxc_main_count.sv
`timescale 1ns/1ps
module dxc_main_count #(
  parameter int CNT_W = 16,
  localparam int LW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             byte_stb,
  input  logic             word_stb,
  output logic             active,
  output logic [LW-1:0]    cnt,
  output logic             term_pulse,
  output logic             odd_resid
);
  localparam logic [LW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic          stb;
  logic [LW-1:0] step;

  assign stb  = byte_stb | word_stb;
  assign step = word_stb ? LW'(2) : LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      term_pulse <= 1'b0;
      odd_resid  <= 1'b0;
    end else if (load) begin
      active     <= 1'b1;
      cnt        <= (load_val == '0) ? FULL : {1'b0, load_val};
      term_pulse <= 1'b0;
      odd_resid  <= 1'b0;
    end else begin
      term_pulse <= 1'b0;
      if (active && stb) begin
        if (cnt <= step) begin
          cnt        <= '0;
          term_pulse <= 1'b1;
          active     <= 1'b0;
          if (cnt < step) odd_resid <= 1'b1;
        end else begin
          cnt <= cnt - step;
        end
      end
    end
  end

  a_r5_tc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(cnt));
  a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r2_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && byte_stb && !word_stb && cnt > LW'(1)) |=> (cnt == $past(cnt) - LW'(1)));
  a_r7_odd_end: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && word_stb && cnt == LW'(1)) |=> (odd_resid && term_pulse && cnt == '0));
endmodule

// File: rtl/dxc_buf_count.sv
`timescale 1ns/1ps
module dxc_buf_count #(
  parameter int CNT_W = 16,
  localparam int LW = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             byte_stb,
  input  logic             word_stb,
  output logic [LW-1:0]    left,
  output logic             full_pulse
);
  localparam logic [LW-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [LW-1:0] step;
  assign step = word_stb ? LW'(2) : LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left       <= '0;
      full_pulse <= 1'b0;
    end else if (load) begin
      left       <= (load_val == '0) ? FULL : {1'b0, load_val};
      full_pulse <= 1'b0;
    end else begin
      full_pulse <= 1'b0;
      if (enable && left != '0 && (byte_stb || word_stb)) begin
        if (left <= step) begin
          left       <= '0;
          full_pulse <= 1'b1;
        end else begin
          left <= left - step;
        end
      end
    end
  end

  a_r11_full_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    full_pulse |=> !full_pulse);
  a_r11_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !load) |=> (left == '0));
endmodule

// File: rtl/dma_xfer_counter.sv
`timescale 1ns/1ps
module dma_xfer_counter #(
  parameter int HALF_W = 8,
  localparam int CNT_W = 2 * HALF_W,
  localparam int LW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              chain_mode,
  input  logic              rx_dir,
  input  logic              word_bus,
  input  logic              start,
  input  logic              buf_start,
  input  logic              byte_done,
  input  logic              word_done,
  output logic              active,
  output logic [LW-1:0]     remaining,
  output logic [LW-1:0]     buf_left,
  output logic              term_cnt,
  output logic              buf_full,
  output logic              cfg_err,
  output logic              odd_resid
);
  logic [CNT_W-1:0] count_val;
  logic [CNT_W-1:0] len_val;
  logic             len_ok;
  logic             chain_rx;
  logic             setup_bad;
  logic             try_start;
  logic             go;
  logic             chain_rx_q;
  logic             buf_load;

  assign chain_rx  = chain_mode & rx_dir;
  assign setup_bad = chain_rx && (!len_ok || (word_bus && len_val == CNT_W'(1)));
  assign try_start = start && !active;
  assign go        = try_start && !setup_bad;
  assign buf_load  = (go && chain_rx) || (buf_start && active && chain_rx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err    <= 1'b0;
      chain_rx_q <= 1'b0;
    end else if (try_start) begin
      cfg_err <= setup_bad;
      if (!setup_bad) chain_rx_q <= chain_rx;
    end
  end

  dxc_cfg_regs #(.HALF_W(HALF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .busy      (active),
    .count_val (count_val),
    .len_val   (len_val),
    .len_ok    (len_ok)
  );

  dxc_main_count #(.CNT_W(CNT_W)) u_main (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (go),
    .load_val   (count_val),
    .byte_stb   (byte_done),
    .word_stb   (word_done),
    .active     (active),
    .cnt        (remaining),
    .term_pulse (term_cnt),
    .odd_resid  (odd_resid)
  );

  dxc_buf_count #(.CNT_W(CNT_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (active && chain_rx_q),
    .load       (buf_load),
    .load_val   (len_val),
    .byte_stb   (byte_done),
    .word_stb   (word_done),
    .left       (buf_left),
    .full_pulse (buf_full)
  );

  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (try_start && setup_bad) |=> (!active && cfg_err));
  a_r8_no_buf_full: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !chain_rx_q) |=> !buf_full);
endmodule

// File: tb/dma_xfer_counter_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, chain_mode = 0, rx_dir = 0, word_bus = 0;
  logic start = 0, buf_start = 0, byte_done = 0, word_done = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic active, term_cnt, buf_full, cfg_err, odd_resid;
  logic [16:0] remaining, buf_left;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dma_xfer_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .chain_mode(chain_mode), .rx_dir(rx_dir), .word_bus(word_bus), .start(start),
    .buf_start(buf_start), .byte_done(byte_done), .word_done(word_done),
    .active(active), .remaining(remaining), .buf_left(buf_left), .term_cnt(term_cnt),
    .buf_full(buf_full), .cfg_err(cfg_err), .odd_resid(odd_resid)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic set_count(input logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic go(input logic ch, input logic rx, input logic wb);
    chain_mode = ch; rx_dir = rx; word_bus = wb; start = 1; tick(); start = 0;
  endtask

  task automatic pulse(input logic b, input logic w);
    byte_done = b; word_done = w; tick(); byte_done = 0; word_done = 0;
  endtask

  task automatic hold_word(input int n);
    word_done = 1; repeat (n) @(posedge clk); #1; word_done = 0;
  endtask

  task automatic drain();
    byte_done = 1;
    for (int i = 0; i < 200 && active; i++) tick();
    byte_done = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R5 reset active", active, 0);
    chk("R5 reset term_cnt", term_cnt, 0);
    chk("R11 reset buf_full", buf_full, 0);
    chk("R9 reset cfg_err", cfg_err, 0);
    chk("R1 reset remaining", remaining, 0);
  endtask

  task automatic t_idle_ignore();
    pulse(1, 0);
    chk("R6 idle byte remaining", remaining, 0);
    chk("R6 idle byte term", term_cnt, 0);
    pulse(0, 1);
    chk("R6 idle word remaining", remaining, 0);
  endtask

  task automatic t_halves();
    set_count(16'h0102);
    go(0, 0, 1);
    chk("R1 active after start", active, 1);
    chk("R1 loaded halves", remaining, 258);
    hold_word(128);
    chk("R3 word steps", remaining, 2);
    pulse(1, 0);
    chk("R2 byte step", remaining, 1);
    chk("R5 no early term", term_cnt, 0);
    pulse(1, 0);
    chk("R5 term pulse", term_cnt, 1);
    chk("R5 active drops", active, 0);
    chk("R5 zero reached", remaining, 0);
    tick();
    chk("R5 term one cycle", term_cnt, 0);
  endtask

  task automatic t_odd();
    set_count(16'd5);
    go(0, 0, 1);
    pulse(0, 1);
    chk("R3 word minus two", remaining, 3);
    pulse(1, 1);
    chk("R3 both strobes word wins", remaining, 1);
    pulse(0, 1);
    chk("R7 saturate zero", remaining, 0);
    chk("R7 odd flag", odd_resid, 1);
    chk("R7 term on odd", term_cnt, 1);
    go(0, 0, 1);
    chk("R7 odd cleared", odd_resid, 0);
    chk("R7 reload", remaining, 5);
    drain();
  endtask

  task automatic t_block();
    set_count(16'd4);
    go(0, 0, 1);
    wr(2'd0, 8'd9);
    chk("R12 running count unchanged", remaining, 4);
    drain();
    go(0, 0, 1);
    chk("R12 blocked write", remaining, 4);
    drain();
  endtask

  task automatic t_zero();
    set_count(16'd0);
    go(0, 0, 1);
    chk("R4 zero means full", remaining, 65536);
    hold_word(32767);
    chk("R4 near end", remaining, 2);
    pulse(1, 0);
    pulse(1, 0);
    chk("R4 full length term", term_cnt, 1);
    chk("R4 full length idle", active, 0);
  endtask

  task automatic t_len_ignored();
    set_count(16'd2);
    go(0, 1, 1);
    chk("R8 single starts", active, 1);
    chk("R8 single no err", cfg_err, 0);
    pulse(1, 0);
    chk("R8 single no buf_full", buf_full, 0);
    chk("R8 single buf_left", buf_left, 0);
    drain();
    go(1, 0, 1);
    chk("R8 chained tx starts", active, 1);
    chk("R8 chained tx no err", cfg_err, 0);
    pulse(1, 0);
    chk("R8 chained tx no buf_full", buf_full, 0);
    drain();
  endtask

  task automatic t_len_missing();
    set_count(16'd2);
    go(1, 1, 1);
    chk("R9 refused no length", cfg_err, 1);
    chk("R9 stays idle", active, 0);
    wr(2'd2, 8'd4);
    go(1, 1, 1);
    chk("R9 refused half length", cfg_err, 1);
    wr(2'd3, 8'd0);
    go(1, 1, 1);
    chk("R9 accepted", active, 1);
    chk("R9 err cleared", cfg_err, 0);
    chk("R11 loaded at start", buf_left, 4);
    drain();
  endtask

  task automatic t_len_one();
    wr(2'd2, 8'd1); wr(2'd3, 8'd0);
    set_count(16'd3);
    go(1, 1, 1);
    chk("R10 len one refused", cfg_err, 1);
    chk("R10 len one idle", active, 0);
    go(1, 1, 0);
    chk("R10 byte bus accepted", active, 1);
    chk("R10 byte bus no err", cfg_err, 0);
    pulse(1, 0);
    chk("R11 len one full", buf_full, 1);
    drain();
  endtask

  task automatic t_buffer();
    wr(2'd2, 8'd3); wr(2'd3, 8'd0);
    set_count(16'd10);
    go(1, 1, 1);
    chk("R11 start load", buf_left, 3);
    pulse(1, 0);
    chk("R11 byte dec", buf_left, 2);
    chk("R11 not yet full", buf_full, 0);
    pulse(0, 1);
    chk("R11 word to zero", buf_left, 0);
    chk("R11 full pulse", buf_full, 1);
    pulse(1, 0);
    chk("R11 full one cycle", buf_full, 0);
    chk("R11 hold empty", buf_left, 0);
    chk("R2 main keeps counting", remaining, 6);
    buf_start = 1; tick(); buf_start = 0;
    chk("R11 reload", buf_left, 3);
    drain();
    wr(2'd2, 8'd0);
    go(1, 1, 1);
    chk("R11 zero length full", buf_left, 65536);
    drain();
  endtask

  initial begin
    #1_900_000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_idle_ignore();
    t_halves();
    t_odd();
    t_block();
    t_zero();
    t_len_ignored();
    t_len_missing();
    t_len_one();
    t_buffer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule